// File: doc/BRIEF.md
# Byte-Synchronous Serial Transmitter

This block is the transmit side of a character-oriented synchronous serial link. Software-side logic configures two sync characters, an idle fill byte, an idle-fill select bit, a framing mode and a CRC enable. It then feeds data bytes into a four-entry buffer. One bit goes out on `txd` for every cycle in which the bit-clock enable `bit_en` is high. Every character goes out least-significant bit first.

When the transmitter is enabled and has nothing to send, it fills the line with mark or with the programmed idle byte. A header can therefore be placed on the line simply by holding back the first data write. As soon as data is waiting at a character boundary, the block sends the first sync character. In two-sync mode it then sends the second sync character. After that it sends the buffered bytes in arrival order. When the buffer runs dry it can append a 16-bit CRC. It then returns to idle fill.

The block has three commands. A reset command stops it at once. An enable command starts it. A disable command is graceful: the buffered data, plus its CRC, still goes out before the line drops to mark.

Top module: `bsync_tx`

## Requirements
- R1: The `rst_n` reset and the `cmd_reset` pulse both put the block into the stopped state on the next clock edge, even in the middle of a character. After that edge `txd` is 1, `tx_ready` is 0 and the buffer is empty.
- R2: While stopped, `txd` stays 1 and `tx_ready` stays 0. Both `bit_en` and writes (`wr_en`) have no effect in this state.
- R3: A `cmd_enable` pulse moves a stopped transmitter to idle. While idle with an empty buffer, each character is 8'hFF when `cfg_idle_sel`=0, or `cfg_idle_pat` repeated when `cfg_idle_sel`=1.
- R4: Each character is sent LSB first, one bit per `bit_en` cycle. `txd` takes the new bit on the clock edge where `bit_en` is high, and does not change otherwise (except on reset). State changes happen only at character boundaries.
- R5: At a character boundary in idle, if the buffer holds data, the next character is `cfg_sync1`.
- R6: With `cfg_mode`=2'b01 (two-sync), `cfg_sync2` follows `cfg_sync1`. With 2'b00 (one-sync) and 2'b10 (external sync), the data follows `cfg_sync1` directly.
- R7: Data bytes go out in the order they were written. The buffer holds 4 bytes. `tx_ready` is 1 when the block is enabled and the buffer is not full. A write while `tx_ready` is 0 is dropped.
- R8: When the buffer is empty at a data-character boundary and `cfg_crc_en`=1, a 16-bit CRC is sent, bit 15 first, and the block then returns to idle. The CRC uses polynomial 16'h1021 and starts from all ones. It covers every data bit of the message in line order and does not include the sync characters. With `cfg_crc_en`=0 the block goes straight back to idle.
- R9: After `cmd_disable`, the block keeps sending until the buffer is empty, including the CRC if one is enabled. It then stops at the next boundary with `txd`=1 and `tx_ready`=0. `tx_ready` stays 1 until that point.
- R10: When the block is idle with an empty buffer, a pending disable takes effect at the next character boundary. That character's bits are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per pulse |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Graceful disable command pulse |
| cmd_reset | input | 1 | Immediate stop command pulse, flushes buffer |
| cfg_mode | input | 2 | 00 one-sync, 01 two-sync, 10 external sync |
| cfg_idle_sel | input | 1 | 0 idle mark, 1 idle pattern |
| cfg_crc_en | input | 1 | Append CRC after each message |
| cfg_sync1 | input | 8 | First sync character |
| cfg_sync2 | input | 8 | Second sync character (two-sync mode) |
| cfg_idle_pat | input | 8 | Idle fill byte |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Buffer write byte |
| txd | output | 1 | Serial data line |
| tx_ready | output | 1 | Enabled and buffer not full |

## Verification
Each line bit is due on the clock edge that samples `bit_en` high. The monitor reads `txd` at the falling edge right after that edge and compares it with the next bit from the expected-bit queue. The driver task fills that queue character by character: idle fill, sync, data, CRC, and the mark that follows a stop.

Commands and writes take effect on the following edge. The bench therefore checks `tx_ready` and the post-reset `txd` one falling edge after the pulse. It ticks only whole characters, except in the reset-mid-character case, where it expects only the bits sent before the reset.

// File: rtl/bsync_tx_pkg.sv
package bsync_tx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_SYNA,
        ST_SYNB,
        ST_DATA,
        ST_CRC
    } tx_state_e;

    localparam logic [1:0] MODE_ONE = 2'b00;
    localparam logic [1:0] MODE_TWO = 2'b01;
    localparam logic [1:0] MODE_EXT = 2'b10;

endpackage

// File: rtl/bsync_tx_fifo.sv
module bsync_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == CW'(DEPTH));
    assign head  = mem_q[p_q.rd];

    always_comb begin
        p_d     = p_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wr = p_q.wr + PW'(1);
            if (do_pop)  p_d.rd = p_q.rd + PW'(1);
            if (do_push && !do_pop)      p_d.cnt = p_q.cnt + CW'(1);
            else if (do_pop && !do_push) p_d.cnt = p_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= push_data;
    end

endmodule

// File: rtl/bsync_tx_crc.sv
module bsync_tx_crc #(
    parameter int          DW   = 8,
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021
) (
    input  logic [CW-1:0] crc_i,
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] crc_o
);
    always_comb begin
        logic [CW-1:0] c;
        logic          fb;
        c = crc_i;
        for (int i = 0; i < DW; i++) begin
            fb = c[CW-1] ^ data_i[i];
            c  = {c[CW-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        crc_o = c;
    end
endmodule

// File: rtl/bsync_tx.sv
module bsync_tx #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CRC_W      = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_idle_sel,
    input  logic              cfg_crc_en,
    input  logic [DATA_W-1:0] cfg_sync1,
    input  logic [DATA_W-1:0] cfg_sync2,
    input  logic [DATA_W-1:0] cfg_idle_pat,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready
);
    import bsync_tx_pkg::*;

    localparam int SH_W = (CRC_W > DATA_W) ? CRC_W : DATA_W;
    localparam int LW   = $clog2(SH_W);
    localparam logic [LW-1:0] CHAR_LAST = LW'(DATA_W - 1);
    localparam logic [LW-1:0] CRC_LAST  = LW'(CRC_W - 1);

    typedef struct packed {
        tx_state_e        state;
        logic             txd;
        logic [SH_W-1:0]  sh;
        logic [LW-1:0]    left;
        logic [CRC_W-1:0] crc;
        logic             dis_pend;
    } regs_t;

    regs_t r_d, r_q;

    logic              fifo_empty, fifo_full, fifo_pop, fifo_push;
    logic [DATA_W-1:0] fifo_head;
    logic [CRC_W-1:0]  crc_next, crc_rev;
    logic              ld, go_idle;
    logic [SH_W-1:0]   ld_val;
    logic [LW-1:0]     ld_last;

    assign tx_ready  = (r_q.state != ST_OFF) && !fifo_full;
    assign fifo_push = wr_en && tx_ready && !cmd_reset;
    assign txd       = r_q.txd;

    bsync_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cmd_reset),
        .push     (fifo_push),
        .push_data(wr_data),
        .pop      (fifo_pop),
        .head     (fifo_head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    bsync_tx_crc #(.DW(DATA_W), .CW(CRC_W), .POLY(CRC_POLY)) crc_i (
        .crc_i (r_q.crc),
        .data_i(fifo_head),
        .crc_o (crc_next)
    );

    // CRC leaves MSB first through an LSB-first shifter: load it mirrored.
    always_comb begin
        for (int i = 0; i < CRC_W; i++) crc_rev[i] = r_q.crc[CRC_W-1-i];
    end

    always_comb begin
        r_d      = r_q;
        fifo_pop = 1'b0;
        ld       = 1'b0;
        ld_val   = '0;
        ld_last  = CHAR_LAST;
        go_idle  = 1'b0;

        if (cmd_reset) begin
            r_d.state    = ST_OFF;
            r_d.txd      = 1'b1;
            r_d.sh       = '0;
            r_d.left     = '0;
            r_d.dis_pend = 1'b0;
        end else begin
            if (cmd_enable) begin
                r_d.dis_pend = 1'b0;
                if (r_q.state == ST_OFF) begin
                    r_d.state = ST_IDLE;
                    r_d.left  = '0;
                end
            end else if (cmd_disable && r_q.state != ST_OFF) begin
                r_d.dis_pend = 1'b1;
            end

            if (bit_en && r_q.state != ST_OFF) begin
                if (r_q.left != '0) begin
                    r_d.txd  = r_q.sh[0];
                    r_d.sh   = r_q.sh >> 1;
                    r_d.left = r_q.left - LW'(1);
                end else begin
                    case (r_q.state)
                        ST_IDLE, ST_CRC: go_idle = 1'b1;
                        ST_SYNA: begin
                            if (cfg_mode == MODE_TWO) begin
                                r_d.state = ST_SYNB;
                                ld        = 1'b1;
                                ld_val    = SH_W'(cfg_sync2);
                            end else begin
                                r_d.state = ST_DATA;
                                fifo_pop  = 1'b1;
                            end
                        end
                        ST_SYNB: begin
                            r_d.state = ST_DATA;
                            fifo_pop  = 1'b1;
                        end
                        ST_DATA: begin
                            if (!fifo_empty) begin
                                fifo_pop = 1'b1;
                            end else if (cfg_crc_en) begin
                                r_d.state = ST_CRC;
                                ld        = 1'b1;
                                ld_val    = SH_W'(crc_rev);
                                ld_last   = CRC_LAST;
                            end else begin
                                go_idle = 1'b1;
                            end
                        end
                        default: ;
                    endcase

                    if (fifo_pop) begin
                        r_d.crc = crc_next;
                        ld      = 1'b1;
                        ld_val  = SH_W'(fifo_head);
                    end

                    if (go_idle) begin
                        if (!fifo_empty) begin
                            r_d.state = ST_SYNA;
                            r_d.crc   = CRC_INIT;
                            ld        = 1'b1;
                            ld_val    = SH_W'(cfg_sync1);
                        end else if (r_d.dis_pend) begin
                            r_d.state    = ST_OFF;
                            r_d.txd      = 1'b1;
                            r_d.dis_pend = 1'b0;
                        end else begin
                            r_d.state = ST_IDLE;
                            ld        = 1'b1;
                            ld_val    = cfg_idle_sel ? SH_W'(cfg_idle_pat)
                                                     : SH_W'({DATA_W{1'b1}});
                        end
                    end

                    if (ld) begin
                        r_d.txd  = ld_val[0];
                        r_d.sh   = ld_val >> 1;
                        r_d.left = ld_last;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_OFF;
            r_q.txd      <= 1'b1;
            r_q.crc      <= CRC_INIT;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/bsync_tx_chk.sv
module bsync_tx_chk
    import bsync_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       cmd_enable,
    input logic       cmd_reset,
    input logic       crc_en,
    input logic [1:0] mode,
    input logic       txd,
    input logic       tx_ready,
    input tx_state_e  st
);
    // R1
    rst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (txd && !tx_ready && st == ST_OFF));

    // R2
    off_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> (txd && !tx_ready));

    // R3
    enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enable && !cmd_reset && st == ST_OFF) |=> (st == ST_IDLE));

    // R4
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !cmd_reset) |=> $stable(txd));

    // R6
    one_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SYNA && mode != MODE_TWO) |=> (st != ST_SYNB));

    // R8
    no_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && !crc_en && !cmd_reset) |=> (st != ST_CRC));
endmodule

bind bsync_tx bsync_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .cmd_enable(cmd_enable),
    .cmd_reset (cmd_reset),
    .crc_en    (cfg_crc_en),
    .mode      (cfg_mode),
    .txd       (txd),
    .tx_ready  (tx_ready),
    .st        (r_q.state)
);

// File: tb/bsync_tx_tb_top.sv
module bsync_tx_tb_top;
    localparam time CYC = 5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       cfg_idle_sel = 1'b0, cfg_crc_en = 1'b0;
    logic [7:0] cfg_sync1 = 8'h32, cfg_sync2 = 8'h6B, cfg_idle_pat = 8'h3C;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, tx_ready;

    int errors = 0;
    int checks = 0;
    bit exp_q[$];
    string tag_q[$];
    logic [15:0] crc_m;

    always #(CYC/2) clk = ~clk;

    bsync_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .cfg_mode(cfg_mode), .cfg_idle_sel(cfg_idle_sel), .cfg_crc_en(cfg_crc_en),
        .cfg_sync1(cfg_sync1), .cfg_sync2(cfg_sync2), .cfg_idle_pat(cfg_idle_pat),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver side: expected line bits
    task automatic exp_char(logic [7:0] c, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(c[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic exp_crc(logic [15:0] c, string tag);
        for (int i = 15; i >= 0; i--) begin
            exp_q.push_back(c[i]);
            tag_q.push_back(tag);
        end
    endtask

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            if (c[15] ^ b[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    // expected message: sync(s), data, optional CRC
    task automatic exp_msg(logic [7:0] d[$], bit two, bit crc);
        logic [15:0] c;
        c = 16'hFFFF;
        exp_char(cfg_sync1, 8, "R5 sync1");
        if (two) exp_char(cfg_sync2, 8, "R6 sync2");
        foreach (d[i]) begin
            exp_char(d[i], 8, "R7 data");
            c = crc_byte(c, d[i]);
        end
        if (crc) exp_crc(c, "R8 crc");
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_en = 1'b1;
            @(negedge clk) bit_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic write(logic [7:0] b);
        @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pulse_enable();
        @(negedge clk) cmd_enable = 1'b1;
        @(negedge clk) cmd_enable = 1'b0;
    endtask

    task automatic pulse_disable();
        @(negedge clk) cmd_disable = 1'b1;
        @(negedge clk) cmd_disable = 1'b0;
    endtask

    // monitor: compare each line bit after the edge that took bit_en
    initial begin
        forever begin
            @(posedge clk);
            if (bit_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R4 unexpected bit actual=%b expected=none", txd);
                end else begin
                    check(tag_q.pop_front(), txd, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] m[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset txd", txd, 1'b1);
        check("R1 reset ready", tx_ready, 1'b0);

        // R2: stopped, bit_en and write have no effect
        exp_char(8'hFF, 3, "R2 stopped mark");
        ticks(3);
        write(8'hAA);
        check("R2 ready while stopped", tx_ready, 1'b0);

        // R3: enable, idle mark then idle pattern
        pulse_enable();
        check("R3 ready after enable", tx_ready, 1'b1);
        exp_char(8'hFF, 8, "R3 idle mark");
        ticks(8);
        cfg_idle_sel = 1'b1;
        exp_char(8'h3C, 8, "R3 idle pattern");
        exp_char(8'h3C, 8, "R3 idle pattern");
        ticks(16);

        // R5 R7 R4: one-sync, no CRC, then idle
        write(8'hA5); write(8'h5A);
        m = '{8'hA5, 8'h5A};
        exp_msg(m, 1'b0, 1'b0);
        exp_char(8'h3C, 8, "R8 idle after data");
        ticks(32);

        // R6 R8: two-sync with CRC
        cfg_mode = 2'b01; cfg_crc_en = 1'b1;
        write(8'h12); write(8'h34); write(8'h81);
        m = '{8'h12, 8'h34, 8'h81};
        exp_msg(m, 1'b1, 1'b1);
        exp_char(8'h3C, 8, "R8 idle after crc");
        ticks(8 * 6 + 16);

        // R6: external sync skips second sync
        cfg_mode = 2'b10;
        write(8'hC3);
        m = '{8'hC3};
        exp_msg(m, 1'b0, 1'b1);
        ticks(8 * 2 + 16);

        // R7: fill buffer, fifth write dropped
        cfg_mode = 2'b00; cfg_crc_en = 1'b0;
        write(8'h01); write(8'h02); write(8'h03);
        check("R7 ready at 3", tx_ready, 1'b1);
        write(8'h04);
        check("R7 ready when full", tx_ready, 1'b0);
        write(8'hEE);
        m = '{8'h01, 8'h02, 8'h03, 8'h04};
        exp_msg(m, 1'b0, 1'b0);
        exp_char(8'h3C, 8, "R7 dropped write absent");
        ticks(8 * 6);

        // R9: graceful disable
        cfg_crc_en = 1'b1;
        write(8'h77); write(8'h88);
        pulse_disable();
        check("R9 ready while draining", tx_ready, 1'b1);
        m = '{8'h77, 8'h88};
        exp_msg(m, 1'b0, 1'b1);
        exp_char(8'hFF, 8, "R9 mark after drain");
        ticks(8 * 3 + 16 + 8);
        check("R9 ready after stop", tx_ready, 1'b0);
        write(8'h55);
        pulse_enable();
        exp_char(8'h3C, 8, "R2 write while stopped dropped");
        ticks(8);

        // R10: disable from empty idle
        pulse_disable();
        exp_char(8'hFF, 8, "R10 idle disable mark");
        ticks(8);
        check("R10 ready after stop", tx_ready, 1'b0);

        // R1: reset command mid-character flushes buffer
        pulse_enable();
        write(8'h99); write(8'h66);
        exp_char(cfg_sync1, 4, "R1 partial sync");
        ticks(4);
        @(negedge clk) cmd_reset = 1'b1;
        @(negedge clk) cmd_reset = 1'b0;
        check("R1 cmd reset txd", txd, 1'b1);
        check("R1 cmd reset ready", tx_ready, 1'b0);
        pulse_enable();
        exp_char(8'h3C, 8, "R1 buffer flushed");
        ticks(8);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 leftover bits actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule